// File: doc/BRIEF.md
# Four-Lane Single-Precision to Unsigned Word Truncating Converter

This block takes a 128-bit vector holding four IEEE-754 single-precision values and turns each one into an unsigned 32-bit integer. It drops any fraction, so it always rounds toward zero. Values that do not fit are clamped to 0 or to 0xFFFF_FFFF. It sits in a vector execution pipeline and produces its results one clock after the operands arrive.

Each lane is first sorted into a class by a fixed ordering of value regions: at or below -1, between -1 and 0, zero, a fraction between 0 and 1, an in-range value, at or above 2^32, quiet NaN and signalling NaN. The class and the two trap-enable inputs then decide the lane's value, whether the lane is written, and which exception it raises. The exception outputs are the OR of the four lanes' conditions. A lane whose enabled exception fires withholds its own write, and the other lanes are still written.

Top module: `fp32x4_utrunc`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, all outputs are zero after that edge.
- R2: Lane i of `src_vec` (bits 32i+31 to 32i, i = 0..3) maps to the same bit range of `res_vec` and to `lane_we[i]`. Results appear on the first clock edge after the inputs are presented.
- R3: A source that is an exact integer in [1, 2^32) gives that integer, with the lane written and no flag raised.
- R4: A source at or below -1 (including -infinity), or a source of +0 or -0, gives 0 with the lane written and no flag raised.
- R5: A source strictly between -1 and 0 (including negative denormals) gives 0. If `trap_inv_en` is 1, `exc_invalid` is raised and the lane is not written. Otherwise the lane is written.
- R6: A positive non-integer source below 2^32 (including positive denormals) gives its truncated value. If `trap_inx_en` is 1, `exc_inexact` is raised and the lane is not written. Otherwise the lane is written with no flag.
- R7: A source at or above 2^32 (including +infinity) gives 0xFFFF_FFFF. If `trap_inv_en` is 1, `exc_invalid` is raised and the lane is not written.
- R8: A quiet NaN (exponent field 255, fraction nonzero, fraction bit 22 = 1) gives 0. If `trap_inv_en` is 1, `exc_invalid` is raised and the lane is not written.
- R9: A signalling NaN (exponent field 255, fraction nonzero, fraction bit 22 = 0) behaves as in R8, and also raises `exc_snan` when `trap_inv_en` is 1.
- R10: Each exception output is the OR of its condition over the four lanes. Only the lanes that raise an enabled exception have `lane_we` low. `res_vec` carries each lane's default value whether or not the lane is written.
- R11: With both trap enables at 0, all four `lane_we` bits are 1 and no exception output is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vec | input | 128 | Four single-precision source lanes |
| trap_inv_en | input | 1 | Invalid-operation trap enable |
| trap_inx_en | input | 1 | Inexact trap enable |
| res_vec | output | 128 | Four unsigned 32-bit results |
| lane_we | output | 4 | Per-lane write enable |
| exc_invalid | output | 1 | Invalid conversion occurred in some lane |
| exc_snan | output | 1 | Signalling NaN trapped in some lane |
| exc_inexact | output | 1 | Inexact result trapped in some lane |

## Verification
The bench targets the region boundaries: exactly -1, -0, the smallest denormals of each sign, 2^32 against the largest single below it, and the infinities. A design that placed a boundary in the wrong region would return 0 where 0xFFFF_FFFF is due, or raise a flag where none belongs. It also mixes trapping and non-trapping lanes in one vector, which exposes a design that suppresses writes to the whole vector or lets a flag leak from one lane into another. Signalling and quiet NaNs are sent with the invalid trap both on and off, so a design that reports a signalling NaN without also reporting the invalid flag, or that flags while the trap is off, produces a mismatch.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;

    localparam int LANE_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = BIAS + LANE_W;          // first exponent at or above 2^32
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp32_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NEG_BIG,
        CL_NEG_FRAC,
        CL_POS_FRAC,
        CL_INRANGE,
        CL_OVER,
        CL_QNAN,
        CL_SNAN
    } lane_class_e;

    typedef struct packed {
        logic [LANE_W-1:0] value;
        logic              wr;
        logic              inv;
        logic              snan;
        logic              inx;
    } lane_res_t;

    // integer part of a normal value with exponent in [BIAS, EXP_TOP)
    function automatic logic [LANE_W-1:0] trunc_mag(input logic [EXP_W-1:0] e,
                                                    input logic [FRAC_W-1:0] f);
        logic [4:0]        sh;
        logic [LANE_W-1:0] m;
        sh = 5'(e - EXP_W'(BIAS));
        m  = LANE_W'({1'b1, f});
        if (sh >= 5'(FRAC_W))
            return m << (sh - 5'(FRAC_W));
        else
            return m >> (5'(FRAC_W) - sh);
    endfunction

    // nonzero fraction bits discarded by the truncation
    function automatic logic frac_lost(input logic [EXP_W-1:0] e,
                                       input logic [FRAC_W-1:0] f);
        logic [4:0]        sh;
        logic [FRAC_W-1:0] mask;
        sh   = 5'(e - EXP_W'(BIAS));
        mask = {FRAC_W{1'b1}} >> sh;
        return (sh < 5'(FRAC_W)) && (|(f & mask));
    endfunction

endpackage

// File: rtl/fp2u_classify.sv
module fp2u_classify
    import fp2u_pkg::*;
(
    input  logic [LANE_W-1:0] word,
    output lane_class_e       cls,
    output logic [LANE_W-1:0] mag,
    output logic              lost
);
    fp32_t op;
    assign op = fp32_t'(word);

    always_comb begin
        if (op.exp == EXP_ALL1) begin
            if (op.frac == '0)
                cls = op.sign ? CL_NEG_BIG : CL_OVER;
            else
                cls = op.frac[FRAC_W-1] ? CL_QNAN : CL_SNAN;
        end else if (op.exp == '0 && op.frac == '0) begin
            cls = CL_ZERO;
        end else if (op.sign) begin
            cls = (op.exp >= EXP_W'(BIAS)) ? CL_NEG_BIG : CL_NEG_FRAC;
        end else if (op.exp < EXP_W'(BIAS)) begin
            cls = CL_POS_FRAC;
        end else if (op.exp >= EXP_W'(EXP_TOP)) begin
            cls = CL_OVER;
        end else begin
            cls = CL_INRANGE;
        end
    end

    assign mag  = trunc_mag(op.exp, op.frac);
    assign lost = frac_lost(op.exp, op.frac);

endmodule

// File: rtl/fp2u_policy.sv
module fp2u_policy
    import fp2u_pkg::*;
(
    input  lane_class_e       cls,
    input  logic [LANE_W-1:0] mag,
    input  logic              lost,
    input  logic              inv_en,
    input  logic              inx_en,
    output lane_res_t         res
);
    always_comb begin
        res = '{value: '0, wr: 1'b1, inv: 1'b0, snan: 1'b0, inx: 1'b0};
        unique case (cls)
            CL_ZERO, CL_NEG_BIG: ;
            CL_NEG_FRAC, CL_QNAN: begin
                res.inv = inv_en;
                res.wr  = ~inv_en;
            end
            CL_SNAN: begin
                res.inv  = inv_en;
                res.snan = inv_en;
                res.wr   = ~inv_en;
            end
            CL_POS_FRAC: begin
                res.inx = inx_en;
                res.wr  = ~inx_en;
            end
            CL_INRANGE: begin
                res.value = mag;
                res.inx   = lost & inx_en;
                res.wr    = ~(lost & inx_en);
            end
            CL_OVER: begin
                res.value = '1;
                res.inv   = inv_en;
                res.wr    = ~inv_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fp32x4_utrunc.sv
module fp32x4_utrunc
    import fp2u_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES*LANE_W-1:0]  src_vec,
    input  logic                     trap_inv_en,
    input  logic                     trap_inx_en,
    output logic [LANES*LANE_W-1:0]  res_vec,
    output logic [LANES-1:0]         lane_we,
    output logic                     exc_invalid,
    output logic                     exc_snan,
    output logic                     exc_inexact
);
    localparam int VEC_W = LANES * LANE_W;

    lane_res_t         lane_r [LANES];
    logic [VEC_W-1:0]  res_d;
    logic [LANES-1:0]  we_d;
    logic              inv_d, snan_d, inx_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_class_e       cls;
        logic [LANE_W-1:0] mag;
        logic              lost;

        fp2u_classify u_cls (
            .word (src_vec[g*LANE_W +: LANE_W]),
            .cls  (cls),
            .mag  (mag),
            .lost (lost)
        );

        fp2u_policy u_pol (
            .cls    (cls),
            .mag    (mag),
            .lost   (lost),
            .inv_en (trap_inv_en),
            .inx_en (trap_inx_en),
            .res    (lane_r[g])
        );

        assign res_d[g*LANE_W +: LANE_W] = lane_r[g].value;
        assign we_d[g]                   = lane_r[g].wr;
    end

    always_comb begin
        inv_d  = 1'b0;
        snan_d = 1'b0;
        inx_d  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            inv_d  = inv_d  | lane_r[i].inv;
            snan_d = snan_d | lane_r[i].snan;
            inx_d  = inx_d  | lane_r[i].inx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec     <= '0;
            lane_we     <= '0;
            exc_invalid <= 1'b0;
            exc_snan    <= 1'b0;
            exc_inexact <= 1'b0;
        end else begin
            res_vec     <= res_d;
            lane_we     <= we_d;
            exc_invalid <= inv_d;
            exc_snan    <= snan_d;
            exc_inexact <= inx_d;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_vec == '0 && lane_we == '0 && !exc_invalid && !exc_snan && !exc_inexact));

    // R9
    snan_needs_inv_chk: assert property (@(posedge clk) disable iff (rst)
        exc_snan |-> exc_invalid);

    // R10
    flag_drops_we_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_invalid || exc_inexact) |-> (lane_we != '1));

    // R11
    quiet_all_written_chk: assert property (@(posedge clk) disable iff (rst)
        (!trap_inv_en && !trap_inx_en) |=> (lane_we == '1 && !exc_invalid && !exc_snan && !exc_inexact));

    // R5
    no_inv_wo_en_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_inv_en |=> (!exc_invalid && !exc_snan));

    // R6
    no_inx_wo_en_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_inx_en |=> !exc_inexact);

endmodule

// File: tb/fp32x4_utrunc_tb.sv
`timescale 1ns/1ps
module fp32x4_utrunc_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] src_vec = '0;
    logic         trap_inv_en = 1'b0;
    logic         trap_inx_en = 1'b0;
    logic [127:0] res_vec;
    logic [3:0]   lane_we;
    logic         exc_invalid, exc_snan, exc_inexact;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fp32x4_utrunc u_dut (
        .clk(clk), .rst(rst), .src_vec(src_vec),
        .trap_inv_en(trap_inv_en), .trap_inx_en(trap_inx_en),
        .res_vec(res_vec), .lane_we(lane_we),
        .exc_invalid(exc_invalid), .exc_snan(exc_snan), .exc_inexact(exc_inexact)
    );

    typedef struct packed {
        logic [127:0] v;
        logic         inv_en;
        logic         inx_en;
    } stim_t;

    stim_t pend[$];

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic real fp_val(input logic [31:0] w);
        real m;
        int  e;
        e = int'(w[30:23]);
        if (e == 0) m = real'(w[22:0]) * (2.0 ** (-149));
        else        m = real'({1'b1, w[22:0]}) * (2.0 ** (e - 150));
        return w[31] ? -m : m;
    endfunction

    // behavioural reference for one lane
    task automatic ref_lane(input logic [31:0] w, input logic ie, input logic xe,
                            output logic [31:0] val, output logic wr,
                            output logic inv, output logic sn, output logic inx,
                            output string tag);
        real    v;
        longint li;
        val = 0; wr = 1; inv = 0; sn = 0; inx = 0;
        if (w[30:23] == 8'hFF && w[22:0] != 0) begin
            inv = ie; wr = !ie;
            if (!w[22]) begin sn = ie; tag = "R9"; end
            else tag = "R8";
        end else if (w[30:23] == 8'hFF) begin
            if (w[31]) tag = "R4";
            else begin val = 32'hFFFF_FFFF; inv = ie; wr = !ie; tag = "R7"; end
        end else begin
            v = fp_val(w);
            if (v <= -1.0) tag = "R4";
            else if (v < 0.0) begin inv = ie; wr = !ie; tag = "R5"; end
            else if (v == 0.0) tag = "R4";
            else if (v >= 4294967296.0) begin val = 32'hFFFF_FFFF; inv = ie; wr = !ie; tag = "R7"; end
            else begin
                li = longint'(v);
                if (real'(li) > v) li = li - 1;
                val = li[31:0];
                if (real'(li) != v) begin inx = xe; wr = !xe; tag = "R6"; end
                else tag = "R2/R3";
            end
        end
    endtask

    task automatic compare(input stim_t s);
        logic [31:0] val;
        logic        wr, inv, sn, inx;
        logic        any_inv, any_sn, any_inx;
        string       tag;
        any_inv = 0; any_sn = 0; any_inx = 0;
        for (int i = 0; i < 4; i++) begin
            ref_lane(s.v[i*32 +: 32], s.inv_en, s.inx_en, val, wr, inv, sn, inx, tag);
            any_inv |= inv; any_sn |= sn; any_inx |= inx;
            check(tag, $sformatf("lane%0d value", i), longint'(res_vec[i*32 +: 32]), longint'(val));
            check((!s.inv_en && !s.inx_en) ? "R11" : "R10", $sformatf("lane%0d we (%s)", i, tag),
                  longint'(lane_we[i]), longint'(wr));
        end
        check("R10", "exc_invalid", longint'(exc_invalid), longint'(any_inv));
        check("R10", "exc_snan",    longint'(exc_snan),    longint'(any_sn));
        check("R10", "exc_inexact", longint'(exc_inexact), longint'(any_inx));
    endtask

    task automatic apply(input logic [127:0] v, input logic ie, input logic xe);
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());
        src_vec = v; trap_inv_en = ie; trap_inx_en = xe;
        pend.push_back('{v: v, inv_en: ie, inx_en: xe});
    endtask

    function automatic logic [31:0] rnd_fp();
        logic [31:0] w;
        int          k;
        w = $urandom;
        k = int'($urandom % 16);
        if (k < 11)       w[30:23] = 8'(100 + ($urandom % 70));
        else if (k == 11) w[30:23] = 8'hFF;
        else if (k == 12) w[30:23] = 8'h00;
        else if (k == 13) begin w[30:23] = 8'(127 + ($urandom % 32)); w[15:0] = 16'h0; end
        return w;
    endfunction

    initial begin
        src_vec = {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000};
        trap_inv_en = 1'b1; trap_inx_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds everything at zero
        check("R1", "res_vec", longint'(res_vec[63:0] | res_vec[127:64]), 0);
        check("R1", "lane_we", longint'(lane_we), 0);
        check("R1", "flags", longint'({exc_invalid, exc_snan, exc_inexact}), 0);
        rst = 1'b0;

        // R2/R3 exact integers, lane order distinct
        apply({32'h4F00_0000, 32'h4780_0000, 32'h4000_0000, 32'h3F80_0000}, 1, 1);
        apply({32'h4F7F_FFFF, 32'h4B00_0001, 32'h4E80_0000, 32'h4120_0000}, 1, 1);
        // R4 at/below -1, -inf, +0, -0
        apply({32'h8000_0000, 32'h0000_0000, 32'hFF80_0000, 32'hBF80_0000}, 1, 1);
        // R5/R6 fractions, traps off then on
        apply({32'h0000_0001, 32'h3FC0_0000, 32'h8000_0001, 32'hBF00_0000}, 0, 0);
        apply({32'h0000_0001, 32'h3FC0_0000, 32'h8000_0001, 32'hBF00_0000}, 1, 1);
        apply({32'h4B7F_FFFF, 32'h3FC0_0000, 32'h8000_0001, 32'hBF00_0000}, 0, 1);
        // R7/R8/R9 overflow and NaNs, trap on then off
        apply({32'h7F80_0001, 32'h7FC0_0000, 32'h7F80_0000, 32'h4F80_0000}, 1, 0);
        apply({32'h7F80_0001, 32'h7FC0_0000, 32'h7F80_0000, 32'h4F80_0000}, 0, 0);
        apply({32'hFFBF_FFFF, 32'hFFC0_0001, 32'h7F7F_FFFF, 32'hCF80_0000}, 1, 1);
        // R10 mixed lanes: one trapping lane only
        apply({32'h4120_0000, 32'h7F80_0001, 32'h3FC0_0000, 32'h4000_0000}, 0, 1);
        apply({32'h4120_0000, 32'h7F80_0001, 32'h3FC0_0000, 32'h4000_0000}, 1, 0);

        for (int n = 0; n < 3000; n++)
            apply({rnd_fp(), rnd_fp(), rnd_fp(), rnd_fp()}, 1'($urandom), 1'($urandom));
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule